// File: doc/BRIEF.md
# Page-Group Access Checker

This block decides, for every memory reference, whether the protection domain now running may touch the page named by a translation lookup. The lookup hands over the page's group identifier, a small rights field, a page-level write-disable bit and the kind of access (load or store). The current privilege level comes from the processor. A group identifier of zero names a global page that every domain may reach. Any other identifier must match one of a small set of page-group registers that hold the groups the current domain owns. Each of these registers carries a valid bit and a write-disable bit of its own.

When a reference passes the group check, the rights field sets the lowest privilege level allowed to read and the lowest allowed to write. A store is also refused when the page or the matching group register has write-disable set. The verdict comes one cycle after the lookup as either a grant or an access violation, with a cause code. A group miss has a separate flag so that the kernel can reload a register. The block tracks how recently each group register was used and offers a victim index for that reload. Software loads the registers through a one-register-per-cycle write port.

Top module: `pgc_access_checker`

## Requirements
- R1: After reset, all group registers are invalid and every result output is low. The victim index is 0. Recency order runs from entry 0 (most recent) to entry N-1 (least recent).
- R2: A lookup presented in cycle t yields res_valid_o in cycle t+1, with exactly one of grant_o or viol_o high. With no lookup, res_valid_o, grant_o and viol_o stay low.
- R3: A lookup with group identifier 0 bypasses the group registers and never raises gmiss_o.
- R4: A non-zero identifier passes the group check only if it equals the identifier of a register whose valid bit is set. A register with its valid bit cleared never matches.
- R5: A non-zero identifier that matches no valid register gives viol_o, gmiss_o and cause 1.
- R6: The rights field holds the minimum read level in bits [1:0] and the minimum write level in bits [3:2]. A load is refused with cause 2 when the current level is below the read minimum, and a store is refused with cause 2 when it is below the write minimum. Level 3 is the most privileged.
- R7: A store is refused with cause 3 when the page write-disable input is set, or when the matching register's write-disable bit is set. Loads ignore both bits.
- R8: When more than one cause applies, the reported cause is chosen in this order: group miss (1) first, then privilege (2), then write-disable (3). A grant reports cause 0.
- R9: A write through the register port affects lookups from the next cycle onward. A lookup in the same cycle as the write still sees the old register contents.
- R10: victim_o is the lowest-numbered invalid register. When every register is valid, victim_o is the least recently used register.
- R11: A lookup that matches a register makes that register the most recently used, and so does any port write to it. When both happen in one cycle, the written register ends up most recent.
- R12: When several valid registers hold the same identifier, the lowest-numbered one supplies the write-disable bit and receives the recency update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid_i | input | 1 | Lookup present this cycle |
| lk_gid_i | input | GID_W | Page group identifier (0 = global) |
| lk_rights_i | input | 2*PL_W | {write minimum level, read minimum level} |
| lk_wd_i | input | 1 | Page-level write-disable |
| lk_store_i | input | 1 | 1 = store, 0 = load |
| cur_pl_i | input | PL_W | Current privilege level (higher = more privileged) |
| gw_en_i | input | 1 | Group register write strobe |
| gw_idx_i | input | IDX_W | Register index to write |
| gw_gid_i | input | GID_W | Identifier to load |
| gw_valid_i | input | 1 | Valid bit to load |
| gw_wd_i | input | 1 | Write-disable bit to load |
| res_valid_o | output | 1 | Verdict present |
| grant_o | output | 1 | Access granted |
| viol_o | output | 1 | Access violation |
| gmiss_o | output | 1 | Violation caused by a group miss |
| cause_o | output | 2 | 0 none, 1 group miss, 2 privilege, 3 write-disable |
| victim_o | output | IDX_W | Register suggested for reload |

## Verification
The bench aims at the cases where the cause priority matters. One is a miss at a low privilege level, which a design with the wrong order would report as cause 2. Another is a store at low privilege to a write-disabled group, which it would report as cause 3. A lookup in the same cycle as a write to the identifier it asks for must still miss; a design that forwards the write would grant it. Invalidated registers and duplicate identifiers are also exercised. A design that ignores the valid bit would grant stale groups. A design that picks the wrong duplicate would apply the wrong write-disable bit or age the wrong entry. The victim index is compared after every operation against an ordered recency model, which exposes aging faults and a missing preference for invalid entries.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_GMISS = 2'd1,
        CAUSE_PRIV  = 2'd2,
        CAUSE_WDIS  = 2'd3
    } cause_e;

endpackage

// File: rtl/pgc_group_regs.sv
module pgc_group_regs #(
    parameter int NREG  = 4,
    parameter int GID_W = 15,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gw_en_i,
    input  logic [IDX_W-1:0] gw_idx_i,
    input  logic [GID_W-1:0] gw_gid_i,
    input  logic             gw_valid_i,
    input  logic             gw_wd_i,
    input  logic [GID_W-1:0] lk_gid_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic             hit_wd_o,
    output logic [NREG-1:0]  valid_o
);

    typedef struct packed {
        logic             vld;
        logic             wd;
        logic [GID_W-1:0] gid;
    } grp_ent_t;

    grp_ent_t [NREG-1:0] ent_d, ent_q;
    logic     [NREG-1:0] match;

    // Per-entry comparators
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign match[g]   = ent_q[g].vld && (ent_q[g].gid == lk_gid_i);
        assign valid_o[g] = ent_q[g].vld;
    end

    // Lowest index wins among duplicates
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        hit_wd_o  = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o     = 1'b1;
                hit_idx_o = IDX_W'(i);
                hit_wd_o  = ent_q[i].wd;
            end
        end
    end

    always_comb begin
        ent_d = ent_q;
        if (gw_en_i) begin
            ent_d[gw_idx_i].vld = gw_valid_i;
            ent_d[gw_idx_i].wd  = gw_wd_i;
            ent_d[gw_idx_i].gid = gw_gid_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    // R9: a port write lands in the addressed entry on the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gw_en_i |=> (valid_o[$past(gw_idx_i)] == $past(gw_valid_i)));

    // R4: a reported hit always points at a valid entry
    p_hit_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> valid_o[hit_idx_o]);

endmodule

// File: rtl/pgc_lru.sv
module pgc_lru #(
    parameter int NREG = 4,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_a_en_i,
    input  logic [IDX_W-1:0] touch_a_idx_i,
    input  logic             touch_b_en_i,
    input  logic [IDX_W-1:0] touch_b_idx_i,
    input  logic [NREG-1:0]  valid_i,
    output logic [IDX_W-1:0] victim_o
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NREG - 1);

    typedef logic [NREG-1:0][IDX_W-1:0] age_arr_t;

    age_arr_t age_d, age_q;
    logic     [NREG-1:0] seen;
    logic     found;

    // Move entry k to age 0, shift younger entries by one
    function automatic age_arr_t touch(input age_arr_t a, input logic [IDX_W-1:0] k);
        age_arr_t r;
        r = a;
        for (int i = 0; i < NREG; i++) begin
            if (a[i] < a[k]) begin
                r[i] = a[i] + 1'b1;
            end
        end
        r[k] = '0;
        return r;
    endfunction

    always_comb begin
        age_d = age_q;
        if (touch_a_en_i) begin
            age_d = touch(age_d, touch_a_idx_i);
        end
        if (touch_b_en_i) begin
            age_d = touch(age_d, touch_b_idx_i);
        end
    end

    // Prefer lowest invalid entry, else the oldest one
    always_comb begin
        victim_o = '0;
        found    = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (!found && !valid_i[i]) begin
                victim_o = IDX_W'(i);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NREG; i++) begin
                if (age_q[i] == OLDEST) begin
                    victim_o = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else begin
            age_q <= age_d;
        end
    end

    always_comb begin
        seen = '0;
        for (int i = 0; i < NREG; i++) begin
            seen[age_q[i]] = 1'b1;
        end
    end

    // R11: ages always form a permutation
    p_age_perm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == NREG);

    // R11: a port write makes its entry the youngest
    p_write_mru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        touch_b_en_i |=> (age_q[$past(touch_b_idx_i)] == '0));

endmodule

// File: rtl/pgc_rights.sv
module pgc_rights #(
    parameter int PL_W = 2
) (
    input  logic [2*PL_W-1:0] rights_i,
    input  logic [PL_W-1:0]   pl_i,
    input  logic              store_i,
    input  logic              page_wd_i,
    input  logic              grp_hit_i,
    input  logic              grp_wd_i,
    output logic              priv_ok_o,
    output logic              wd_block_o
);

    logic [PL_W-1:0] min_rd, min_wr, need;

    assign min_rd     = rights_i[PL_W-1:0];
    assign min_wr     = rights_i[2*PL_W-1:PL_W];
    assign need       = store_i ? min_wr : min_rd;
    assign priv_ok_o  = (pl_i >= need);
    assign wd_block_o = store_i && (page_wd_i || (grp_hit_i && grp_wd_i));

endmodule

// File: rtl/pgc_access_checker.sv
module pgc_access_checker
    import pgc_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int GID_W = 15,
    parameter int PL_W  = 2,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid_i,
    input  logic [GID_W-1:0]  lk_gid_i,
    input  logic [2*PL_W-1:0] lk_rights_i,
    input  logic              lk_wd_i,
    input  logic              lk_store_i,
    input  logic [PL_W-1:0]   cur_pl_i,
    input  logic              gw_en_i,
    input  logic [IDX_W-1:0]  gw_idx_i,
    input  logic [GID_W-1:0]  gw_gid_i,
    input  logic              gw_valid_i,
    input  logic              gw_wd_i,
    output logic              res_valid_o,
    output logic              grant_o,
    output logic              viol_o,
    output logic              gmiss_o,
    output logic [1:0]        cause_o,
    output logic [IDX_W-1:0]  victim_o
);

    typedef struct packed {
        logic   vld;
        logic   grant;
        logic   viol;
        logic   gmiss;
        cause_e cause;
    } res_t;

    res_t             res_d, res_q;
    logic             is_global;
    logic             hit, hit_wd, grp_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [NREG-1:0]  valid;
    logic             group_ok, priv_ok, wd_block;

    assign is_global = (lk_gid_i == '0);

    pgc_group_regs #(.NREG(NREG), .GID_W(GID_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .gw_en_i    (gw_en_i),
        .gw_idx_i   (gw_idx_i),
        .gw_gid_i   (gw_gid_i),
        .gw_valid_i (gw_valid_i),
        .gw_wd_i    (gw_wd_i),
        .lk_gid_i   (lk_gid_i),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .hit_wd_o   (hit_wd),
        .valid_o    (valid)
    );

    assign grp_hit  = hit && !is_global;
    assign group_ok = is_global || hit;

    pgc_rights #(.PL_W(PL_W)) u_rights (
        .rights_i   (lk_rights_i),
        .pl_i       (cur_pl_i),
        .store_i    (lk_store_i),
        .page_wd_i  (lk_wd_i),
        .grp_hit_i  (grp_hit),
        .grp_wd_i   (hit_wd),
        .priv_ok_o  (priv_ok),
        .wd_block_o (wd_block)
    );

    pgc_lru #(.NREG(NREG)) u_lru (
        .clk           (clk),
        .rst_n         (rst_n),
        .touch_a_en_i  (lk_valid_i && grp_hit),
        .touch_a_idx_i (hit_idx),
        .touch_b_en_i  (gw_en_i),
        .touch_b_idx_i (gw_idx_i),
        .valid_i       (valid),
        .victim_o      (victim_o)
    );

    always_comb begin
        res_d = '0;
        if (lk_valid_i) begin
            res_d.vld = 1'b1;
            if (!group_ok) begin
                res_d.viol  = 1'b1;
                res_d.gmiss = 1'b1;
                res_d.cause = CAUSE_GMISS;
            end else if (!priv_ok) begin
                res_d.viol  = 1'b1;
                res_d.cause = CAUSE_PRIV;
            end else if (wd_block) begin
                res_d.viol  = 1'b1;
                res_d.cause = CAUSE_WDIS;
            end else begin
                res_d.grant = 1'b1;
                res_d.cause = CAUSE_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid_o = res_q.vld;
    assign grant_o     = res_q.grant;
    assign viol_o      = res_q.viol;
    assign gmiss_o     = res_q.gmiss;
    assign cause_o     = res_q.cause;

    // R2: one-cycle latency, and silence without a lookup
    p_lookup_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_i |=> res_valid_o);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_i |=> (!res_valid_o && !grant_o && !viol_o));
    p_verdict_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (grant_o ^ viol_o));

    // R3: global pages never report a group miss
    p_global_no_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid_i && lk_gid_i == '0) |=> !gmiss_o);

    // R5: miss flag travels with a violation of cause 1
    p_miss_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gmiss_o |-> (viol_o && cause_o == 2'd1));

    // R8: a grant never carries a cause code
    p_grant_no_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (cause_o == 2'd0));

endmodule

// File: tb/test_pgc_access_checker.sv
`timescale 1ns/100ps
module test_pgc_access_checker;

    localparam int NREG  = 4;
    localparam int GID_W = 15;
    localparam int PL_W  = 2;
    localparam int IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid_i = 1'b0;
    logic [GID_W-1:0]  lk_gid_i = '0;
    logic [2*PL_W-1:0] lk_rights_i = '0;
    logic              lk_wd_i = 1'b0;
    logic              lk_store_i = 1'b0;
    logic [PL_W-1:0]   cur_pl_i = '0;
    logic              gw_en_i = 1'b0;
    logic [IDX_W-1:0]  gw_idx_i = '0;
    logic [GID_W-1:0]  gw_gid_i = '0;
    logic              gw_valid_i = 1'b0;
    logic              gw_wd_i = 1'b0;
    logic              res_valid_o, grant_o, viol_o, gmiss_o;
    logic [1:0]        cause_o;
    logic [IDX_W-1:0]  victim_o;

    always #2.5 clk = ~clk;

    pgc_access_checker #(.NREG(NREG), .GID_W(GID_W), .PL_W(PL_W)) i_pgc_access_checker (
        .clk(clk), .rst_n(rst_n),
        .lk_valid_i(lk_valid_i), .lk_gid_i(lk_gid_i), .lk_rights_i(lk_rights_i),
        .lk_wd_i(lk_wd_i), .lk_store_i(lk_store_i), .cur_pl_i(cur_pl_i),
        .gw_en_i(gw_en_i), .gw_idx_i(gw_idx_i), .gw_gid_i(gw_gid_i),
        .gw_valid_i(gw_valid_i), .gw_wd_i(gw_wd_i),
        .res_valid_o(res_valid_o), .grant_o(grant_o), .viol_o(viol_o),
        .gmiss_o(gmiss_o), .cause_o(cause_o), .victim_o(victim_o)
    );

    typedef struct {
        logic [4:0] val;   // {grant, viol, gmiss, cause[1:0]}
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // Bench model of the register file and recency order (front = least recent)
    bit m_vld[NREG];
    bit m_wd[NREG];
    int m_gid[NREG];
    int order[$];

    function automatic int model_victim();
        for (int i = 0; i < NREG; i++) if (!m_vld[i]) return i;
        return order[0];
    endfunction

    function automatic void model_touch(int k);
        for (int i = 0; i < order.size(); i++) begin
            if (order[i] == k) begin
                order.delete(i);
                break;
            end
        end
        order.push_back(k);
    endfunction

    function automatic int model_match(int gid);
        for (int i = 0; i < NREG; i++) if (m_vld[i] && m_gid[i] == gid) return i;
        return -1;
    endfunction

    // Verdict from R3-R8
    function automatic logic [4:0] model_verdict(int gid, int rights, bit wd, bit st, int pl);
        int m;
        int need;
        m = (gid == 0) ? -1 : model_match(gid);
        if (gid != 0 && m < 0) return 5'b01101;
        need = st ? ((rights >> 2) & 3) : (rights & 3);
        if (pl < need) return 5'b01010;
        if (st && (wd || (m >= 0 && m_wd[m]))) return 5'b01011;
        return 5'b10000;
    endfunction

    task automatic check(string req, int act, int expv, string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic chk_victim(string req);
        check(req, int'(victim_o), model_victim(), "victim");
    endtask

    task automatic gwrite(int idx, int gid, bit v, bit wd);
        @(negedge clk);
        gw_en_i = 1'b1; gw_idx_i = IDX_W'(idx); gw_gid_i = GID_W'(gid);
        gw_valid_i = v; gw_wd_i = wd;
        @(negedge clk);
        gw_en_i = 1'b0;
        m_vld[idx] = v; m_wd[idx] = wd; m_gid[idx] = gid;
        model_touch(idx);
        chk_victim("R10");
    endtask

    // Lookup, optionally with a port write in the same cycle (R9)
    task automatic lookup(int gid, int rights, bit wd, bit st, int pl, string req,
                          bit wr = 1'b0, int widx = 0, int wgid = 0, bit wv = 1'b0, bit wwd = 1'b0);
        exp_t e;
        int   m;
        e.val = model_verdict(gid, rights, wd, st, pl);
        e.req = req;
        m = (gid == 0) ? -1 : model_match(gid);
        @(negedge clk);
        exp_q.push_back(e);
        lk_valid_i = 1'b1; lk_gid_i = GID_W'(gid); lk_rights_i = 4'(rights);
        lk_wd_i = wd; lk_store_i = st; cur_pl_i = 2'(pl);
        if (wr) begin
            gw_en_i = 1'b1; gw_idx_i = IDX_W'(widx); gw_gid_i = GID_W'(wgid);
            gw_valid_i = wv; gw_wd_i = wwd;
        end
        @(negedge clk);
        lk_valid_i = 1'b0; gw_en_i = 1'b0;
        if (m >= 0) model_touch(m);
        if (wr) begin
            m_vld[widx] = wv; m_wd[widx] = wwd; m_gid[widx] = wgid;
            model_touch(widx);
        end
        chk_victim("R11");
    endtask

    // Monitor: pops expected items as verdicts appear
    always @(negedge clk) begin
        if (rst_n && !done && res_valid_o) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected verdict actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, int'({grant_o, viol_o, gmiss_o, cause_o}), int'(e.val),
                      "{grant,viol,gmiss,cause}");
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_vld[i] = 1'b0; m_wd[i] = 1'b0; m_gid[i] = 0;
        end
        for (int i = NREG - 1; i >= 0; i--) order.push_back(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", int'({res_valid_o, grant_o, viol_o, gmiss_o, cause_o}), 0, "outputs");
        check("R1", int'(victim_o), 0, "victim");
        // R2: idle cycle gives no verdict
        @(negedge clk);
        check("R2", int'(res_valid_o), 0, "idle res_valid");

        // R3: global pages
        lookup(0, 4'h0, 1'b0, 1'b0, 0, "R3");
        lookup(0, 4'h0, 1'b0, 1'b1, 0, "R3");
        // R7: page write-disable on global store, ignored on load
        lookup(0, 4'h0, 1'b1, 1'b1, 3, "R7");
        lookup(0, 4'h0, 1'b1, 1'b0, 0, "R7");
        // R6: global read below minimum
        lookup(0, 4'h2, 1'b0, 1'b0, 1, "R6");
        // R5: miss with all registers invalid
        lookup(5, 4'h0, 1'b0, 1'b0, 3, "R5");

        // Load all registers (R10 checked per write)
        gwrite(0, 5, 1'b1, 1'b0);
        gwrite(1, 9, 1'b1, 1'b1);
        gwrite(2, 12, 1'b1, 1'b0);
        gwrite(3, 20, 1'b1, 1'b0);

        // R4 / R11: hits reorder recency
        lookup(5, 4'h0, 1'b0, 1'b0, 0, "R4");
        lookup(9, 4'h0, 1'b0, 1'b0, 0, "R4");
        lookup(20, 4'h0, 1'b0, 1'b1, 0, "R4");
        // R7: register write-disable blocks store, not load
        lookup(9, 4'h0, 1'b0, 1'b1, 3, "R7");
        lookup(9, 4'h0, 1'b0, 1'b0, 3, "R7");
        // R6: level thresholds, rights = {wr 3, rd 1}
        lookup(12, 4'hD, 1'b0, 1'b0, 0, "R6");
        lookup(12, 4'hD, 1'b0, 1'b0, 1, "R6");
        lookup(12, 4'hD, 1'b0, 1'b1, 2, "R6");
        lookup(12, 4'hD, 1'b0, 1'b1, 3, "R6");
        // R8: miss outranks privilege, privilege outranks write-disable
        lookup(77, 4'hF, 1'b1, 1'b1, 0, "R8");
        lookup(9, 4'hC, 1'b0, 1'b1, 1, "R8");
        lookup(12, 4'h4, 1'b1, 1'b1, 1, "R8");

        // R4 / R10: invalidated register never matches and becomes victim
        gwrite(2, 12, 1'b0, 1'b0);
        lookup(12, 4'h0, 1'b0, 1'b0, 3, "R4");

        // R9: write in the lookup cycle is not seen, next lookup is
        lookup(30, 4'h0, 1'b0, 1'b0, 3, "R9", 1'b1, 2, 30, 1'b1, 1'b0);
        lookup(30, 4'h0, 1'b0, 1'b0, 3, "R9");
        // R11: hit and write to different entries in one cycle
        lookup(5, 4'h0, 1'b0, 1'b0, 3, "R11", 1'b1, 3, 21, 1'b1, 1'b0);
        lookup(20, 4'h0, 1'b0, 1'b0, 3, "R11");

        // R12: duplicate identifier, lowest index governs
        gwrite(3, 9, 1'b1, 1'b0);
        lookup(9, 4'h0, 1'b0, 1'b1, 3, "R12");
        gwrite(1, 40, 1'b1, 1'b0);
        lookup(9, 4'h0, 1'b0, 1'b1, 3, "R12");
        gwrite(0, 9, 1'b1, 1'b1);
        lookup(9, 4'h0, 1'b0, 1'b1, 3, "R12");
        lookup(9, 4'h0, 1'b0, 1'b0, 3, "R12");

        // Back-to-back lookups
        lookup(40, 4'h0, 1'b0, 1'b0, 0, "R2");
        lookup(30, 4'h0, 1'b0, 1'b1, 0, "R2");

        repeat (3) @(negedge clk);
        check("R2", exp_q.size(), 0, "pending verdicts");
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule